// File: doc/BRIEF.md
# Cached Linked-List Queue Engine

This block executes enqueue and dequeue commands on linked-list queues whose descriptors are held on chip. Sixteen descriptor slots each keep a head pointer, a tail pointer and an element count. A command names a slot directly. Commands are accepted through a valid/ready handshake and run strictly in the order they arrive, one per cycle. The link words that chain elements together live in an internal link memory whose read latency is a parameter.

An enqueue appends an element address to the queue in the named slot. It writes the address into the link word of the current tail and then makes that address the new tail. A dequeue returns the current head address on a response strobe. If elements remain, it reads the head's link word, and that word becomes the slot's new head after the memory latency. A dequeue aimed at a slot whose head is still being refilled is held at the command port. Enqueues are never held, because they touch only the tail. Loading descriptors from memory, writing them back, and managing free buffers are handled elsewhere.

Top module: `llq_engine`

## Requirements
- R1: After reset every slot is empty, `cmd_ready` is high and `rsp_valid` is low.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, at most one per cycle. Commands execute in acceptance order. A held command blocks every command behind it. `cmd_op` encodes 0 as enqueue and 1 as dequeue.
- R3: An enqueue to an empty slot makes the given address both head and tail, sets the count to 1 and writes no link word. A later dequeue returns that address.
- R4: An enqueue to a non-empty slot stores the address in the link word of the old tail, makes it the tail and increments the count. Enqueues, including back-to-back enqueues to one slot, are never held.
- R5: For a dequeue accepted at edge k, `rsp_valid` is high for exactly the cycle after edge k+1, carrying the head address with `rsp_err` low. The count is decremented. If elements remain, the head's link word is read and becomes the new head at edge k+1+LAT.
- R6: A dequeue to a slot with a refill in progress is held. For a refilling dequeue accepted at edge k, the next dequeue to that slot is accepted no earlier than edge k+LAT+2. A dequeue to another slot, or one following a dequeue that emptied the slot, is not held.
- R7: An enqueue to a slot whose head refill is outstanding is accepted without delay, and the queue keeps its order.
- R8: A dequeue to an empty slot produces a response with `rsp_err` high and `rsp_addr` zero. It changes no state and makes no memory access.
- R9: Within each slot, dequeues return addresses in the order they were enqueued, independent of traffic on other slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 1 | 0 enqueue, 1 dequeue |
| cmd_slot | input | $clog2(NSLOT) | Descriptor slot addressed |
| cmd_addr | input | AW | Element address to enqueue |
| rsp_valid | output | 1 | Dequeue response strobe |
| rsp_addr | output | AW | Dequeued element address |
| rsp_err | output | 1 | Dequeue hit an empty slot |

## Verification
The hardest condition to reach from the ports is a dequeue arriving while an earlier refill on the same slot is in flight. A second case of the same kind is an enqueue landing during that refill window. The bench forces both by sweeping slots round-robin with one more element per slot than the previous, so consecutive dequeues to the same slot get closer together as the short queues drain. It also adds focused sequences that dequeue one slot back to back and insert an enqueue between refills. For every command, the bench derives the expected hold time and response cycle from the acceptance edge and LAT.

// File: rtl/llq_pkg.sv
package llq_pkg;
  typedef enum logic {
    OP_ENQ = 1'b0,
    OP_DEQ = 1'b1
  } llq_op_e;
endpackage

// File: rtl/llq_desc_store.sv
module llq_desc_store #(
  parameter int NSLOT = 16,
  parameter int AW    = 8,
  localparam int SW   = $clog2(NSLOT),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] rd_slot,
  output logic [AW-1:0] rd_head,
  output logic [AW-1:0] rd_tail,
  output logic [CW-1:0] rd_cnt,
  input  logic          we,
  input  logic [SW-1:0] wslot,
  input  logic          set_head,
  input  logic [AW-1:0] head_val,
  input  logic [AW-1:0] tail_val,
  input  logic [CW-1:0] cnt_val,
  input  logic          set_tail,
  input  logic          rf_we,
  input  logic [SW-1:0] rf_slot,
  input  logic [AW-1:0] rf_head
);
  logic [AW-1:0] head_q [NSLOT];
  logic [AW-1:0] tail_q [NSLOT];
  logic [CW-1:0] cnt_q  [NSLOT];

  assign rd_head = head_q[rd_slot];
  assign rd_tail = tail_q[rd_slot];
  assign rd_cnt  = cnt_q[rd_slot];

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          head_q[g] <= '0;
          tail_q[g] <= '0;
          cnt_q[g]  <= '0;
        end else begin
          if (rf_we && rf_slot == SW'(g)) head_q[g] <= rf_head;
          if (we && wslot == SW'(g)) begin
            cnt_q[g] <= cnt_val;
            if (set_head) head_q[g] <= head_val;
            if (set_tail) tail_q[g] <= tail_val;
          end
        end
      end
    end
  endgenerate

  // R7
  refill_vs_head_set_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_we && we && set_head) |-> (rf_slot != wslot));

  // R5
  refill_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (cnt_q[rf_slot] != '0));
endmodule

// File: rtl/llq_link_mem.sv
module llq_link_mem #(
  parameter int AW    = 8,
  parameter int NSLOT = 16,
  parameter int LAT   = 4,
  localparam int SW   = $clog2(NSLOT),
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  input  logic [SW-1:0] rd_slot,
  output logic          ret_valid,
  output logic [SW-1:0] ret_slot,
  output logic [AW-1:0] ret_data
);
  logic [AW-1:0] mem [DEPTH];
  logic [LAT-1:0][AW-1:0] dat_q;
  logic [LAT-1:0][SW-1:0] slot_q;
  logic [LAT-1:0]         vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    dat_q[0] <= mem[rd_addr];
    for (int i = 1; i < LAT; i++) dat_q[i] <= dat_q[i-1];
  end

  always_ff @(posedge clk) begin
    slot_q[0] <= rd_slot;
    for (int i = 1; i < LAT; i++) slot_q[i] <= slot_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else begin
      vld_q[0] <= rd_en;
      for (int i = 1; i < LAT; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  assign ret_valid = vld_q[LAT-1];
  assign ret_slot  = slot_q[LAT-1];
  assign ret_data  = dat_q[LAT-1];

  // R4
  one_port_op_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !rd_en);
endmodule

// File: rtl/llq_hazard.sv
module llq_hazard #(
  parameter int NSLOT = 16,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_is_deq,
  input  logic [SW-1:0]    cmd_slot,
  input  logic             iss_valid,
  input  logic [SW-1:0]    iss_slot,
  input  logic             ret_valid,
  input  logic [SW-1:0]    ret_slot,
  output logic             cmd_ready,
  output logic [NSLOT-1:0] pending
);
  logic stall;

  generate
    for (genvar g = 0; g < NSLOT; g++) begin : g_pend
      always_ff @(posedge clk) begin
        if (rst) pending[g] <= 1'b0;
        else if (iss_valid && iss_slot == SW'(g)) pending[g] <= 1'b1;
        else if (ret_valid && ret_slot == SW'(g)) pending[g] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    stall = 1'b0;
    if (cmd_valid && cmd_is_deq) begin
      if (pending[cmd_slot]) stall = 1'b1;
      if (iss_valid && iss_slot == cmd_slot) stall = 1'b1;
    end
  end

  assign cmd_ready = !stall;

  // R6
  refill_owner_chk: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> pending[ret_slot]);
endmodule

// File: rtl/llq_engine.sv
module llq_engine #(
  parameter int NSLOT = 16,
  parameter int AW    = 8,
  parameter int LAT   = 4,
  localparam int SW   = $clog2(NSLOT),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_op,
  input  logic [SW-1:0] cmd_slot,
  input  logic [AW-1:0] cmd_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_err
);
  import llq_pkg::*;

  logic          cmd_fire;
  logic          ex_valid;
  llq_op_e       ex_op;
  logic [SW-1:0] ex_slot;
  logic [AW-1:0] ex_addr;
  logic [AW-1:0] ex_head, ex_tail;
  logic [CW-1:0] ex_cnt;
  logic          ex_enq, ex_deq, ex_empty;
  logic          deq_ok, deq_err, link_wr, refill_issue;
  logic          st_we;
  logic [CW-1:0] cnt_next;
  logic          rf_valid;
  logic [SW-1:0] rf_slot;
  logic [AW-1:0] rf_data;
  logic [NSLOT-1:0] pending;

  assign cmd_fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_op    <= OP_ENQ;
      ex_slot  <= '0;
      ex_addr  <= '0;
    end else begin
      ex_valid <= cmd_fire;
      if (cmd_fire) begin
        ex_op   <= llq_op_e'(cmd_op);
        ex_slot <= cmd_slot;
        ex_addr <= cmd_addr;
      end
    end
  end

  assign ex_enq       = ex_valid && (ex_op == OP_ENQ);
  assign ex_deq       = ex_valid && (ex_op == OP_DEQ);
  assign ex_empty     = (ex_cnt == '0);
  assign deq_ok       = ex_deq && !ex_empty;
  assign deq_err      = ex_deq && ex_empty;
  assign link_wr      = ex_enq && !ex_empty;
  assign refill_issue = deq_ok && (ex_cnt > CW'(1));
  assign st_we        = ex_enq || deq_ok;
  assign cnt_next     = ex_enq ? ex_cnt + CW'(1) : ex_cnt - CW'(1);

  llq_desc_store #(.NSLOT(NSLOT), .AW(AW)) store_i (
    .clk      (clk),
    .rst      (rst),
    .rd_slot  (ex_slot),
    .rd_head  (ex_head),
    .rd_tail  (ex_tail),
    .rd_cnt   (ex_cnt),
    .we       (st_we),
    .wslot    (ex_slot),
    .set_head (ex_enq && ex_empty),
    .head_val (ex_addr),
    .tail_val (ex_addr),
    .cnt_val  (cnt_next),
    .set_tail (ex_enq),
    .rf_we    (rf_valid),
    .rf_slot  (rf_slot),
    .rf_head  (rf_data)
  );

  llq_link_mem #(.AW(AW), .NSLOT(NSLOT), .LAT(LAT)) link_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (link_wr),
    .wr_addr   (ex_tail),
    .wr_data   (ex_addr),
    .rd_en     (refill_issue),
    .rd_addr   (ex_head),
    .rd_slot   (ex_slot),
    .ret_valid (rf_valid),
    .ret_slot  (rf_slot),
    .ret_data  (rf_data)
  );

  llq_hazard #(.NSLOT(NSLOT)) hazard_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_is_deq (cmd_op == OP_DEQ),
    .cmd_slot   (cmd_slot),
    .iss_valid  (refill_issue),
    .iss_slot   (ex_slot),
    .ret_valid  (rf_valid),
    .ret_slot   (rf_slot),
    .cmd_ready  (cmd_ready),
    .pending    (pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= ex_deq;
      rsp_addr  <= deq_ok ? ex_head : '0;
      rsp_err   <= deq_err;
    end
  end

  // R5
  refill_marks_pending_chk: assert property (@(posedge clk) disable iff (rst)
    refill_issue |=> pending[$past(ex_slot)]);

  // R2
  accept_to_exec_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_fire |=> ex_valid);

  // R8
  err_rsp_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_addr == '0));
endmodule

// File: tb/llq_engine_tb_top.sv
module llq_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 16;
  localparam int AW    = 8;
  localparam int LAT   = 4;
  localparam int SW    = $clog2(NSLOT);
  localparam int QD    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          cmd_valid;
  logic          cmd_ready;
  logic          cmd_op;
  logic [SW-1:0] cmd_slot;
  logic [AW-1:0] cmd_addr;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic          rsp_err;

  llq_engine #(.NSLOT(NSLOT), .AW(AW), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_addr(cmd_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_err(rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // reference queues
  int mq   [NSLOT][QD];
  bit mfst [NSLOT][QD];
  int mh [NSLOT];
  int mt [NSLOT];
  int earliest [NSLOT];
  int next_addr = 0;

  // expected responses
  int    ea [4096];
  bit    ee [4096];
  int    ec [4096];
  string er [4096];
  int    ewr = 0;
  int    erd = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input bit op, input int slot);
    int stalls;
    int p;
    int k;
    int exp_stall;
    int a;
    @(negedge clk);
    a = next_addr;
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_slot  = SW'(slot);
    cmd_addr  = AW'(a);
    #1;
    p = cyc + 1;
    stalls = 0;
    while (!cmd_ready) begin
      @(negedge clk);
      #1;
      stalls++;
    end
    k = cyc + 1;
    if (op) begin
      exp_stall = (earliest[slot] > p) ? earliest[slot] - p : 0;
      check(stalls == exp_stall, "R6", "dequeue hold cycles", stalls, exp_stall);
      if (mt[slot] - mh[slot] > 0) begin
        ea[ewr % 4096] = mq[slot][mh[slot] % QD];
        ee[ewr % 4096] = 1'b0;
        er[ewr % 4096] = mfst[slot][mh[slot] % QD] ? "R3" : "R9";
        mh[slot]++;
        earliest[slot] = (mt[slot] - mh[slot] > 0) ? k + LAT + 2 : 0;
      end else begin
        ea[ewr % 4096] = 0;
        ee[ewr % 4096] = 1'b1;
        er[ewr % 4096] = "R8";
        earliest[slot] = 0;
      end
      ec[ewr % 4096] = k + 1;
      ewr++;
    end else begin
      check(stalls == 0, (earliest[slot] > p) ? "R7" : "R4",
            "enqueue hold cycles", stalls, 0);
      mfst[slot][mt[slot] % QD] = (mt[slot] == mh[slot]);
      mq[slot][mt[slot] % QD] = a;
      mt[slot]++;
      next_addr = (next_addr + 1) % QD;
    end
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (erd == ewr) begin
        check(1'b0, "R2", "unexpected response", 1, 0);
      end else begin
        check(rsp_err == ee[erd % 4096], "R8", "rsp_err", int'(rsp_err), int'(ee[erd % 4096]));
        check(int'(rsp_addr) == ea[erd % 4096], er[erd % 4096], "rsp_addr",
              int'(rsp_addr), ea[erd % 4096]);
        check(cyc == ec[erd % 4096], "R5", "response cycle", cyc, ec[erd % 4096]);
        erd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) begin
      mh[s] = 0; mt[s] = 0; earliest[s] = 0;
    end
    rst = 1'b1;
    cmd_valid = 1'b0;
    cmd_op = 1'b0;
    cmd_slot = '0;
    cmd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "cmd_ready in reset", int'(cmd_ready), 1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst = 1'b0;

    // R1 R8: every slot empty after reset
    for (int s = 0; s < NSLOT; s++) issue(1'b1, s);

    // R3 R4 R2: staircase fill, slot s receives s+1 elements
    for (int i = 0; i < NSLOT; i++)
      for (int s = 0; s < NSLOT; s++)
        if (i <= s) issue(1'b0, s);

    // R5 R6 R9: staircase drain, same-slot gaps shrink near the end
    for (int i = 0; i < NSLOT; i++)
      for (int s = 0; s < NSLOT; s++)
        if (i <= s) issue(1'b1, s);

    // R8: all drained
    for (int s = 0; s < NSLOT; s++) issue(1'b1, s);

    // R6: back-to-back dequeues on one slot
    for (int j = 0; j < 3; j++) issue(1'b0, 3);
    for (int j = 0; j < 4; j++) issue(1'b1, 3);

    // R7: enqueue while head refill is outstanding
    issue(1'b0, 5);
    issue(1'b0, 5);
    issue(1'b1, 5);
    issue(1'b0, 5);
    issue(1'b1, 5);
    issue(1'b0, 5);
    issue(1'b1, 5);
    issue(1'b1, 5);
    issue(1'b1, 5);

    // mixed traffic over four slots
    for (int j = 0; j < 400; j++) begin
      int s;
      bit d;
      s = (j * 5 + j / 7) % 4;
      d = ((j * 11) % 5) < 2;
      issue(d, s);
    end
    for (int s = 0; s < 4; s++)
      for (int j = 0; j < 3; j++) issue(1'b1, s);
    for (int s = 0; s < NSLOT; s++)
      while (mt[s] - mh[s] > 0) issue(1'b1, s);

    repeat (LAT + 6) @(posedge clk);
    @(negedge clk);
    check(erd == ewr, "R2", "responses outstanding", ewr - erd, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule